// File: doc/BRIEF.md
# I2C bus timing monitor

A passive observer for a two-wire serial bus. It takes the clock line and the data line, cleans each through a two-flop synchronizer and a short glitch filter, and recovers the bus conditions from the filtered levels. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A START that arrives while a transfer is still open is a repeated START. Clock rising edges inside a transfer are data bits, and every ninth one after a START is tagged as the acknowledge slot.

Alongside the conditions, the monitor keeps a saturating age counter for four reference events: the last clock rise, the last data change, the last START and the last STOP. When a closing event arrives, it compares the matching age against a programmable minimum, given in system clock cycles. The checks are hold after START, setup before a repeated START, setup before STOP, data setup and bus free time. A violation produces a one-cycle pulse and a 3-bit code. The block never drives the bus. The package supplies Fast Mode minimums converted at 125 MHz for integrators who want them.

Top module: `i2c_timing_mon`

## Requirements
- R1: `start_pulse` pulses once for each data-line fall while the clock line is high. `stop_pulse` pulses once for each data-line rise while the clock line is high. `restart_pulse` pulses together with `start_pulse` when the START arrives with a transfer already open, meaning after a START and before the next STOP.
- R2: When the first clock fall after a START comes fewer than `min_hd_sta` cycles after that START, a violation with code 1 is reported.
- R3: When a repeated START comes fewer than `min_su_sta` cycles after the most recent clock rise, a violation with code 2 is reported. A START with no transfer open never gets this check.
- R4: When a STOP comes fewer than `min_su_sto` cycles after the most recent clock rise, a violation with code 3 is reported. Nothing is checked after a STOP other than bus free time.
- R5: When a clock rise inside an open transfer comes fewer than `min_su_dat` cycles after the last data-line change, a violation with code 4 is reported. Clock rises while the bus is idle are not checked.
- R6: When a START with no transfer open comes fewer than `min_bus_free` cycles after the previous STOP, a violation with code 5 is reported. Before the first STOP after reset, no bus-free check is made.
- R7: An interval is measured as the difference in clock cycles between the two edges. An interval equal to its minimum passes, and an interval one cycle shorter fails.
- R8: `ack_pulse` pulses on the ninth clock rise after a START, and on every ninth clock rise after that. Both START and STOP reset the bit count.
- R9: A level on either line that lasts fewer than FILT_LEN (default 3) cycles is ignored. A short low on the data line while the clock line is high produces neither a START nor a STOP.
- R10: During and after reset, with both lines high, every output is low.
- R11: `viol_pulse` is high for exactly one cycle per violation. `viol_code` is in the range 1 to 5 while the pulse is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line level |
| sda_in | input | 1 | Raw bus data line level |
| min_hd_sta | input | CNT_W | Minimum cycles from START to the first clock fall |
| min_su_sta | input | CNT_W | Minimum cycles from clock rise to a repeated START |
| min_su_sto | input | CNT_W | Minimum cycles from clock rise to STOP |
| min_su_dat | input | CNT_W | Minimum cycles from data change to clock rise |
| min_bus_free | input | CNT_W | Minimum cycles from STOP to the next fresh START |
| start_pulse | output | 1 | START seen |
| restart_pulse | output | 1 | START seen while a transfer was open |
| stop_pulse | output | 1 | STOP seen |
| ack_pulse | output | 1 | Clock rise of the acknowledge bit |
| viol_pulse | output | 1 | One-cycle violation strobe |
| viol_code | output | 3 | 1 START hold, 2 repeated-START setup, 3 STOP setup, 4 data setup, 5 bus free |

## Verification
The bench drives every interval at exactly its minimum and then one cycle short. A comparison written as less-or-equal would flag the exact case, and an off-by-one in the age counters would miss the short case. It sends a START right after reset: a monitor that checked bus free time with no STOP behind it would report code 5 there. Repeated STARTs are mixed with fresh ones, so a design that applied the repeated-START setup check to every START, or that left the bit count running across a START, would show wrong codes or misplaced acknowledge pulses. Data bits that repeat the previous level make data setup reach back to an older edge, and a two-cycle data-line dip while the bus is idle must not be taken for a START.

// File: rtl/i2ctm_pkg.sv
package i2ctm_pkg;

   typedef enum logic [2:0] {
      VC_NONE       = 3'd0,
      VC_STA_HOLD   = 3'd1,
      VC_RSTA_SETUP = 3'd2,
      VC_STO_SETUP  = 3'd3,
      VC_DAT_SETUP  = 3'd4,
      VC_BUS_FREE   = 3'd5
   } viol_code_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic sda_chg;
      logic start;
      logic stop;
   } bus_evt_t;

   // round a nanosecond figure up to whole system clock cycles
   function automatic int ns_to_cycles(input int ns, input int clk_mhz);
      return (ns * clk_mhz + 999) / 1000;
   endfunction

   localparam int FM_CLK_MHZ  = 125;
   localparam int FM_HD_STA   = ns_to_cycles(600,  FM_CLK_MHZ);
   localparam int FM_SU_STA   = ns_to_cycles(600,  FM_CLK_MHZ);
   localparam int FM_SU_STO   = ns_to_cycles(600,  FM_CLK_MHZ);
   localparam int FM_SU_DAT   = ns_to_cycles(100,  FM_CLK_MHZ);
   localparam int FM_BUS_FREE = ns_to_cycles(1300, FM_CLK_MHZ);

endpackage

// File: rtl/i2ctm_deglitch.sv
module i2ctm_deglitch #(
   parameter int FILT_LEN = 3,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic sync1, sync2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1 <= IDLE_LVL;
         sync2 <= IDLE_LVL;
      end else begin
         sync1 <= raw;
         sync2 <= sync1;
      end
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean <= IDLE_LVL;
            else        clean <= sync2;
         end
      end else begin : g_filter
         localparam int RUN_W = $clog2(FILT_LEN + 1);
         logic [RUN_W-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run   <= '0;
               clean <= IDLE_LVL;
            end else if (sync2 == clean) begin
               run <= '0;
            end else if (run == RUN_W'(FILT_LEN - 1)) begin
               clean <= sync2;
               run   <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2ctm_edge_events.sv
module i2ctm_edge_events
   import i2ctm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_f,
   input  logic     sda_f,
   output bus_evt_t evt
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   always_comb begin
      evt.scl_rise = scl_f & ~scl_q;
      evt.scl_fall = ~scl_f & scl_q;
      evt.sda_chg  = sda_f ^ sda_q;
      // a condition needs the clock line high both before and after the data edge
      evt.start    = sda_q & ~sda_f & scl_q & scl_f;
      evt.stop     = ~sda_q & sda_f & scl_q & scl_f;
   end
endmodule

// File: rtl/i2ctm_age_counter.sv
module i2ctm_age_counter #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   output logic [W-1:0] age
);
   localparam logic [W-1:0] AGE_MAX = '1;

   // reads k in the k-th cycle after the clearing event; saturates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age <= AGE_MAX;
      else if (clear)          age <= W'(1);
      else if (age != AGE_MAX) age <= age + 1'b1;
   end
endmodule

// File: rtl/i2c_timing_mon.sv
module i2c_timing_mon
   import i2ctm_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter int FILT_LEN  = 3,
   parameter int DATA_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic [CNT_W-1:0] min_hd_sta,
   input  logic [CNT_W-1:0] min_su_sta,
   input  logic [CNT_W-1:0] min_su_sto,
   input  logic [CNT_W-1:0] min_su_dat,
   input  logic [CNT_W-1:0] min_bus_free,
   output logic             start_pulse,
   output logic             restart_pulse,
   output logic             stop_pulse,
   output logic             ack_pulse,
   output logic             viol_pulse,
   output logic [2:0]       viol_code
);
   localparam int N_LINE = 2;
   localparam int LN_SCL = 0;
   localparam int LN_SDA = 1;
   localparam int N_AGE  = 4;
   localparam int AG_RISE = 0;
   localparam int AG_SDA  = 1;
   localparam int AG_STA  = 2;
   localparam int AG_STO  = 3;
   localparam int BC_W    = $clog2(DATA_BITS + 1);

   generate
      if (CNT_W < 4 || CNT_W > 24) begin : g_bad_cnt_w
         $error("CNT_W must lie in 4..24");
      end
      if (FILT_LEN < 0 || FILT_LEN > 64) begin : g_bad_filt
         $error("FILT_LEN must lie in 0..64");
      end
      if (DATA_BITS < 1 || DATA_BITS > 32) begin : g_bad_bits
         $error("DATA_BITS must lie in 1..32");
      end
   endgenerate

   // ---------------- line conditioning ----------------
   logic [N_LINE-1:0] raw_lines, clean_lines;
   assign raw_lines[LN_SCL] = scl_in;
   assign raw_lines[LN_SDA] = sda_in;

   generate
      for (genvar l = 0; l < N_LINE; l++) begin : g_line
         i2ctm_deglitch #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[l]),
            .clean (clean_lines[l])
         );
      end
   endgenerate

   bus_evt_t ev;
   i2ctm_edge_events u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_f (clean_lines[LN_SCL]),
      .sda_f (clean_lines[LN_SDA]),
      .evt   (ev)
   );

   // ---------------- event ages ----------------
   logic [N_AGE-1:0] age_clr;
   logic [CNT_W-1:0] age [N_AGE];

   assign age_clr[AG_RISE] = ev.scl_rise;
   assign age_clr[AG_SDA]  = ev.sda_chg;
   assign age_clr[AG_STA]  = ev.start;
   assign age_clr[AG_STO]  = ev.stop;

   generate
      for (genvar g = 0; g < N_AGE; g++) begin : g_age
         i2ctm_age_counter #(.W(CNT_W)) u_age (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (age_clr[g]),
            .age   (age[g])
         );
      end
   endgenerate

   // ---------------- bus state ----------------
   logic            busy_q;
   logic            stop_seen_q;
   logic            hold_pend_q;
   logic [BC_W-1:0] bit_cnt_q;
   logic            ack_now;

   assign ack_now = ev.scl_rise & busy_q & (bit_cnt_q == BC_W'(DATA_BITS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         stop_seen_q <= 1'b0;
         hold_pend_q <= 1'b0;
         bit_cnt_q   <= '0;
      end else if (ev.start) begin
         busy_q      <= 1'b1;
         hold_pend_q <= 1'b1;
         bit_cnt_q   <= '0;
      end else if (ev.stop) begin
         busy_q      <= 1'b0;
         stop_seen_q <= 1'b1;
         hold_pend_q <= 1'b0;
         bit_cnt_q   <= '0;
      end else begin
         if (ev.scl_fall) hold_pend_q <= 1'b0;
         if (ev.scl_rise && busy_q) begin
            if (ack_now) bit_cnt_q <= '0;
            else         bit_cnt_q <= bit_cnt_q + 1'b1;
         end
      end
   end

   // ---------------- interval checks ----------------
   viol_code_e       cur_code;
   logic [CNT_W-1:0] dat_age;

   // a data change in the very cycle of the clock rise leaves zero setup
   assign dat_age = ev.sda_chg ? '0 : age[AG_SDA];

   always_comb begin
      cur_code = VC_NONE;
      if (ev.start) begin
         if (busy_q) begin
            if (age[AG_RISE] < min_su_sta) cur_code = VC_RSTA_SETUP;
         end else if (stop_seen_q && (age[AG_STO] < min_bus_free)) begin
            cur_code = VC_BUS_FREE;
         end
      end else if (ev.stop) begin
         if (age[AG_RISE] < min_su_sto) cur_code = VC_STO_SETUP;
      end else if (ev.scl_fall && hold_pend_q) begin
         if (age[AG_STA] < min_hd_sta) cur_code = VC_STA_HOLD;
      end else if (ev.scl_rise && busy_q) begin
         if (dat_age < min_su_dat) cur_code = VC_DAT_SETUP;
      end
   end

   // ---------------- registered outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse   <= 1'b0;
         restart_pulse <= 1'b0;
         stop_pulse    <= 1'b0;
         ack_pulse     <= 1'b0;
         viol_pulse    <= 1'b0;
         viol_code     <= 3'd0;
      end else begin
         start_pulse   <= ev.start;
         restart_pulse <= ev.start & busy_q;
         stop_pulse    <= ev.stop;
         ack_pulse     <= ack_now;
         viol_pulse    <= (cur_code != VC_NONE);
         viol_code     <= cur_code;
      end
   end
endmodule

// File: rtl/i2ctm_mon_checker.sv
module i2ctm_mon_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start_pulse,
   input logic       restart_pulse,
   input logic       stop_pulse,
   input logic       ack_pulse,
   input logic       viol_pulse,
   input logic [2:0] viol_code
);
   logic open_q, stop_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q      <= 1'b0;
         stop_seen_q <= 1'b0;
      end else begin
         if (start_pulse)     open_q <= 1'b1;
         else if (stop_pulse) open_q <= 1'b0;
         if (stop_pulse) stop_seen_q <= 1'b1;
      end
   end

   AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_pulse |-> viol_code == 3'd0); // R11
   AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (viol_code >= 3'd1 && viol_code <= 3'd5)); // R11
   AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse)); // R1
   AST_RESTART_IS_START: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse |-> start_pulse); // R1
   AST_RESTART_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      restart_pulse |-> open_q); // R1
   AST_HOLD_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_code == 3'd1) |-> (open_q && !start_pulse)); // R2
   AST_RSTA_ONLY_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_code == 3'd2) |-> restart_pulse); // R3
   AST_STO_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_code == 3'd3) |-> stop_pulse); // R4
   AST_DAT_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_code == 3'd4) |-> open_q); // R5
   AST_BUSFREE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && viol_code == 3'd5) |-> (start_pulse && !restart_pulse && stop_seen_q)); // R6
   AST_ACK_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_pulse |-> (!start_pulse && !stop_pulse)); // R8
endmodule

bind i2c_timing_mon i2ctm_mon_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_pulse   (start_pulse),
   .restart_pulse (restart_pulse),
   .stop_pulse    (stop_pulse),
   .ack_pulse     (ack_pulse),
   .viol_pulse    (viol_pulse),
   .viol_code     (viol_code)
);

// File: tb/sim_i2c_timing_mon.sv
`timescale 1ns/1ps
module sim_i2c_timing_mon;
   import i2ctm_pkg::*;

   localparam int CW = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_r = 1'b1;
   logic sda_r = 1'b1;
   logic [CW-1:0] min_hd, min_sta, min_sto, min_dat, min_buf;
   logic start_pulse, restart_pulse, stop_pulse, ack_pulse, viol_pulse;
   logic [2:0] viol_code;

   always #4 clk = ~clk;

   i2c_timing_mon #(.CNT_W(CW), .FILT_LEN(3), .DATA_BITS(8)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_r), .sda_in(sda_r),
      .min_hd_sta(min_hd), .min_su_sta(min_sta), .min_su_sto(min_sto),
      .min_su_dat(min_dat), .min_bus_free(min_buf),
      .start_pulse(start_pulse), .restart_pulse(restart_pulse),
      .stop_pulse(stop_pulse), .ack_pulse(ack_pulse),
      .viol_pulse(viol_pulse), .viol_code(viol_code)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int cyc = 0;

   // observed at the ports
   int obs_v [8];
   int obs_start = 0, obs_rstart = 0, obs_stop = 0, obs_ack = 0, bad_idle = 0;
   // expected from the bench model
   int exp_v [8];
   int exp_start = 0, exp_rstart = 0, exp_stop = 0, exp_ack = 0;
   // bench model state
   bit busy_m = 0, hold_m = 0, stop_seen_m = 0;
   int bc_m = 0;
   int t_rise = -100000, t_sda = -100000, t_start = -100000, t_stop = -100000;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (viol_pulse) obs_v[viol_code] = obs_v[viol_code] + 1;
         if (!viol_pulse && viol_code != 3'd0) bad_idle = bad_idle + 1;
         if (start_pulse)   obs_start  = obs_start + 1;
         if (restart_pulse) obs_rstart = obs_rstart + 1;
         if (stop_pulse)    obs_stop   = obs_stop + 1;
         if (ack_pulse)     obs_ack    = obs_ack + 1;
      end
   end

   function automatic bit too_short(input int got, input int minv);
      return got < minv;
   endfunction

   function automatic string tag_for(input int c);
      case (c)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic int rnd(input int lo, input int hi);
      return lo + int'($urandom % (hi - lo + 1));
   endfunction

   task automatic chk(input bit ok, input string tag, input string ctx, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, ctx, act, expv);
      end
   endtask

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sda_drv(input bit v);
      if (v != sda_r) begin
         if (scl_r) begin
            if (!v) begin
               exp_start++;
               if (busy_m) begin
                  exp_rstart++;
                  if (too_short(cyc - t_rise, int'(min_sta))) exp_v[2]++;
               end else if (stop_seen_m && too_short(cyc - t_stop, int'(min_buf))) begin
                  exp_v[5]++;
               end
               busy_m = 1; hold_m = 1; t_start = cyc; bc_m = 0;
            end else begin
               exp_stop++;
               if (too_short(cyc - t_rise, int'(min_sto))) exp_v[3]++;
               busy_m = 0; hold_m = 0; stop_seen_m = 1; t_stop = cyc; bc_m = 0;
            end
         end
         t_sda = cyc;
      end
      sda_r = v;
   endtask

   task automatic scl_drv(input bit v);
      if (v != scl_r) begin
         if (v) begin
            t_rise = cyc;
            if (busy_m) begin
               if (too_short(cyc - t_sda, int'(min_dat))) exp_v[4]++;
               if (bc_m == 8) begin exp_ack++; bc_m = 0; end
               else bc_m++;
            end
         end else if (hold_m) begin
            if (too_short(cyc - t_start, int'(min_hd))) exp_v[1]++;
            hold_m = 0;
         end
      end
      scl_r = v;
   endtask

   task automatic send_byte(input int t_dat, input int t_high);
      for (int b = 0; b < 9; b++) begin
         wait_c(3);
         sda_drv(1'($urandom % 2));
         wait_c(t_dat);
         scl_drv(1'b1);
         wait_c(t_high);
         scl_drv(1'b0);
      end
   endtask

   // bus idle on entry; ends after STOP
   task automatic xfer(input int nbytes, input bit rep, input int t_buf, input int t_sta,
                       input int t_hd, input int t_dat, input int t_high, input int t_sto);
      wait_c(t_buf);
      sda_drv(1'b0);
      wait_c(t_hd);
      scl_drv(1'b0);
      for (int k = 0; k < nbytes; k++) send_byte(t_dat, t_high);
      if (rep) begin
         wait_c(3);
         sda_drv(1'b1);
         wait_c(t_dat);
         scl_drv(1'b1);
         wait_c(t_sta);
         sda_drv(1'b0);
         wait_c(t_hd);
         scl_drv(1'b0);
         send_byte(t_dat, t_high);
      end
      wait_c(3);
      sda_drv(1'b0);
      wait_c(t_dat);
      scl_drv(1'b1);
      wait_c(t_sto);
      sda_drv(1'b1);
   endtask

   task automatic compare_all(input string ctx);
      wait_c(20);
      for (int c = 1; c <= 5; c++) chk(obs_v[c] == exp_v[c], tag_for(c), ctx, obs_v[c], exp_v[c]);
      chk(obs_start == exp_start, "R1", ctx, obs_start, exp_start);
      chk(obs_rstart == exp_rstart, "R1", ctx, obs_rstart, exp_rstart);
      chk(obs_stop == exp_stop, "R1", ctx, obs_stop, exp_stop);
      chk(obs_ack == exp_ack, "R8", ctx, obs_ack, exp_ack);
   endtask

   function automatic int obs_total();
      return obs_v[1] + obs_v[2] + obs_v[3] + obs_v[4] + obs_v[5];
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed_dummy;
      int base1, base2, base3, base5, tot0;
      seed_dummy = $urandom(32'd7741);
      for (int c = 0; c < 8; c++) begin obs_v[c] = 0; exp_v[c] = 0; end
      min_hd = 12'd10; min_sta = 12'd10; min_sto = 12'd10; min_dat = 12'd6; min_buf = 12'd40;

      // R10 reset state
      wait_c(3);
      chk(viol_pulse == 1'b0 && viol_code == 3'd0, "R10", "in reset", int'(viol_code), 0);
      rst_n = 1'b1;
      wait_c(10);
      chk({start_pulse, restart_pulse, stop_pulse, ack_pulse, viol_pulse} == 5'b0, "R10", "after reset",
          int'({start_pulse, restart_pulse, stop_pulse, ack_pulse, viol_pulse}), 0);

      // R6: START right after reset, no bus-free check
      xfer(1, 1'b0, 3, 10, 10, 6, 5, 10);
      compare_all("first after reset");
      chk(obs_v[5] == 0, "R6", "no bus-free before first STOP", obs_v[5], 0);

      // R7: every interval exactly at its minimum (bus free = 20 + 20)
      tot0 = obs_total();
      xfer(1, 1'b1, 20, 10, 10, 6, 5, 10);
      compare_all("exact minimums");
      chk(obs_total() == tot0, "R7", "equal to minimum passes", obs_total() - tot0, 0);

      // R7: every interval one cycle short
      base1 = obs_v[1]; base2 = obs_v[2]; base3 = obs_v[3]; base5 = obs_v[5];
      xfer(1, 1'b1, 19, 9, 9, 5, 5, 9);
      compare_all("one short");
      chk(obs_v[1] - base1 == 2, "R7", "hold short x2", obs_v[1] - base1, 2);
      chk(obs_v[2] - base2 == 1, "R7", "rstart setup short", obs_v[2] - base2, 1);
      chk(obs_v[3] - base3 == 1, "R7", "stop setup short", obs_v[3] - base3, 1);
      chk(obs_v[5] - base5 == 1, "R7", "bus free short", obs_v[5] - base5, 1);

      // R9: two-cycle data dip while clock high and bus idle
      wait_c(30);
      tot0 = obs_start;
      sda_r = 1'b0;
      wait_c(2);
      sda_r = 1'b1;
      wait_c(20);
      chk(obs_start == tot0, "R9", "glitch gives no START", obs_start - tot0, 0);
      chk(obs_stop == exp_stop, "R9", "glitch gives no STOP", obs_stop, exp_stop);

      // two bytes, fresh START, long gaps
      xfer(2, 1'b0, 30, 12, 14, 8, 6, 12);
      compare_all("two bytes");

      // constrained random
      for (int i = 0; i < 40; i++) begin
         min_hd  = 12'(rnd(4, 20));
         min_sta = 12'(rnd(4, 20));
         min_sto = 12'(rnd(4, 20));
         min_dat = 12'(rnd(3, 12));
         min_buf = 12'(rnd(22, 50));
         xfer(rnd(1, 2), 1'($urandom % 2), rnd(3, 30), rnd(3, 24), rnd(3, 24),
              rnd(3, 14), rnd(3, 10), rnd(3, 24));
         compare_all("random");
      end

      // Fast Mode defaults at 125 MHz, exact then short bus free
      min_hd = 12'(FM_HD_STA); min_sta = 12'(FM_SU_STA); min_sto = 12'(FM_SU_STO);
      min_dat = 12'(FM_SU_DAT); min_buf = 12'(FM_BUS_FREE);
      xfer(1, 1'b1, FM_BUS_FREE, FM_SU_STA, FM_HD_STA, FM_SU_DAT, 8, FM_SU_STO);
      compare_all("fast mode nominal");
      base5 = obs_v[5];
      xfer(1, 1'b0, FM_BUS_FREE - 21, FM_SU_STA, FM_HD_STA, FM_SU_DAT, 8, FM_SU_STO);
      compare_all("fast mode short free");
      chk(obs_v[5] - base5 == 1, "R6", "bus free one short", obs_v[5] - base5, 1);

      // R11: code zero whenever no pulse, and pulse cycles match violations
      chk(bad_idle == 0, "R11", "code outside pulse", bad_idle, 0);
      chk(obs_total() == exp_v[1] + exp_v[2] + exp_v[3] + exp_v[4] + exp_v[5], "R11", "pulse cycles",
          obs_total(), exp_v[1] + exp_v[2] + exp_v[3] + exp_v[4] + exp_v[5]);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule